// File: doc/BRIEF.md
# Shift-and-Mask Bitfield Extract Unit

This unit pulls a bitfield out of a 64-bit operand in one operation that would otherwise need a shift followed by an AND. In its packed-control mode, a 16-bit control word carries both a signed shift amount and a mask width. Certain mask codes mean "leave the shifted value whole". A left shift, a logical right shift, or a shift plus a low-order mask therefore all come from the same control encoding.

In its bit-load mode, the unit takes a linear bit position and a base byte address. It produces the byte address of the word that holds the field, which is the base plus the bit position divided by eight. It also extracts the field from the loaded operand: it shifts right by the bit position modulo eight and then masks by a separate width field. Width codes beyond the supported maximum set an invalid flag and force the result to zero.

All outputs are registered, so each result appears one clock after its inputs. Memory access, decode and operand storage belong to the surrounding pipeline.

Top module: `bitfield_extract`

## Requirements
- R1: In packed-control mode (`modeBitLoad`=0), `ctrlWord[7:0]` is read as a two's-complement shift code. A non-negative code shifts the operand left by the code modulo 64, and zeros fill the low bits.
- R2: A negative shift code shifts the operand right logically by its magnitude modulo 64, and zeros fill the high bits. The code -128 therefore shifts by 0.
- R3: A mask code `ctrlWord[15:8]` in the range 1 to 63 keeps that many low bits of the shifted value and clears every higher bit.
- R4: A mask code of 0, or from 64 to 255 (255 included), applies no mask, so the result is the whole shifted value.
- R5: In bit-load mode (`modeBitLoad`=1), the operand is shifted right logically by `bitPos[2:0]` before masking, and `ctrlWord` has no effect.
- R6: In bit-load mode, a `widthField` of 0 applies no mask, and a value from 1 to 56 keeps that many low bits.
- R7: In bit-load mode, a `widthField` of 57 or more sets `invalidWidth` to 1 and forces `result` to zero. In packed-control mode, `invalidWidth` is always 0.
- R8: `byteAddr` equals `baseAddr + (bitPos >> 3)`, wrapped modulo 2^ADDR_W.
- R9: Every output is registered. It reflects the inputs sampled at the previous rising clock edge. While `rstN` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeBitLoad | input | 1 | 0 = packed-control mode, 1 = bit-load mode |
| operand | input | 64 | Source data word |
| ctrlWord | input | 16 | Shift code [7:0] and mask code [15:8] |
| widthField | input | 8 | Field width used in bit-load mode |
| bitPos | input | ADDR_W | Linear bit position used in bit-load mode |
| baseAddr | input | ADDR_W | Base byte address used in bit-load mode |
| result | output | 64 | Extracted field |
| invalidWidth | output | 1 | Width code out of range in bit-load mode |
| byteAddr | output | ADDR_W | Byte address of the word holding the field |

## Verification
The clocked checks inside the datapath and control sample combinational values on the rising edge. They assume the inputs are settled by then and carry no unknown bits. The bench meets this by driving every input on the falling edge, and by giving every input a defined value from time zero.

The properties that relate `invalidWidth` to the previous mode rely on reset being held for at least one edge before release. The bench holds it for several edges.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  localparam int DATA_W = 64;
  localparam int SH_W   = $clog2(DATA_W);

  typedef struct packed {
    logic            doLeft;
    logic [SH_W-1:0] shAmt;
    logic            maskEn;
    logic [SH_W-1:0] maskW;
    logic            forceZero;
  } ctlStrobes_t;
endpackage

// File: rtl/bfx_ctrl.sv
module bfx_ctrl
  import bfx_pkg::*;
#(
  parameter int MAX_LOAD_W = 56
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        modeBitLoad,
  input  logic [15:0] ctrlWord,
  input  logic [7:0]  widthField,
  input  logic [2:0]  bitPosLow,
  output ctlStrobes_t strobes
);
  logic [7:0] shByte;
  logic [7:0] negMag;
  logic [7:0] maskCode;

  assign shByte   = ctrlWord[7:0];
  assign negMag   = 8'd0 - shByte;
  assign maskCode = ctrlWord[15:8];

  always_comb begin
    strobes = '0;
    if (modeBitLoad) begin
      strobes.doLeft    = 1'b0;
      strobes.shAmt     = SH_W'(bitPosLow);
      strobes.maskEn    = (widthField != 8'd0) && (int'(widthField) <= MAX_LOAD_W);
      strobes.maskW     = widthField[SH_W-1:0];
      strobes.forceZero = int'(widthField) > MAX_LOAD_W;
    end else begin
      strobes.doLeft    = ~shByte[7];
      strobes.shAmt     = shByte[7] ? negMag[SH_W-1:0] : shByte[SH_W-1:0];
      strobes.maskEn    = (maskCode != 8'd0) && (int'(maskCode) < DATA_W);
      strobes.maskW     = maskCode[SH_W-1:0];
      strobes.forceZero = 1'b0;
    end
  end

  // R7
  no_invalid_in_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    !modeBitLoad |-> !strobes.forceZero);

  // R6
  load_mask_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeBitLoad && strobes.maskEn) |-> (int'(widthField) <= MAX_LOAD_W));

  // R5
  load_right_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeBitLoad |-> !strobes.doLeft);
endmodule

// File: rtl/bfx_dpath.sv
module bfx_dpath
  import bfx_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [DATA_W-1:0] operand,
  input  logic [ADDR_W-1:0] bitPos,
  input  logic [ADDR_W-1:0] baseAddr,
  output logic [DATA_W-1:0] fieldOut,
  output logic [ADDR_W-1:0] addrOut
);
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] maskVec;
  logic [DATA_W-1:0] masked;

  always_comb begin
    if (strobes.doLeft) shifted = operand << strobes.shAmt;
    else                shifted = operand >> strobes.shAmt;
    maskVec  = (DATA_W'(1) << strobes.maskW) - DATA_W'(1);
    masked   = strobes.maskEn ? (shifted & maskVec) : shifted;
    fieldOut = strobes.forceZero ? '0 : masked;
  end

  assign addrOut = baseAddr + (bitPos >> 3);

  // R3
  mask_clears_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.maskEn |-> ((fieldOut >> strobes.maskW) == '0));

  // R7
  force_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.forceZero |-> (fieldOut == '0));

  // R2
  right_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.doLeft && strobes.shAmt != '0) |->
      ((fieldOut >> (DATA_W - int'(strobes.shAmt))) == '0));

  // R1
  left_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doLeft && strobes.shAmt != '0) |->
      ((fieldOut << (DATA_W - int'(strobes.shAmt))) == '0));
endmodule

// File: rtl/bitfield_extract.sv
module bitfield_extract
  import bfx_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int MAX_LOAD_W = 56
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeBitLoad,
  input  logic [63:0]       operand,
  input  logic [15:0]       ctrlWord,
  input  logic [7:0]        widthField,
  input  logic [ADDR_W-1:0] bitPos,
  input  logic [ADDR_W-1:0] baseAddr,
  output logic [63:0]       result,
  output logic              invalidWidth,
  output logic [ADDR_W-1:0] byteAddr
);
  ctlStrobes_t       strobes;
  logic [DATA_W-1:0] fieldOut;
  logic [ADDR_W-1:0] addrOut;

  bfx_ctrl #(.MAX_LOAD_W(MAX_LOAD_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .modeBitLoad(modeBitLoad),
    .ctrlWord   (ctrlWord),
    .widthField (widthField),
    .bitPosLow  (bitPos[2:0]),
    .strobes    (strobes)
  );

  bfx_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .operand (operand),
    .bitPos  (bitPos),
    .baseAddr(baseAddr),
    .fieldOut(fieldOut),
    .addrOut (addrOut)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result       <= '0;
      invalidWidth <= 1'b0;
      byteAddr     <= '0;
    end else begin
      result       <= fieldOut;
      invalidWidth <= strobes.forceZero;
      byteAddr     <= addrOut;
    end
  end

  // R9
  invalid_from_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    invalidWidth |-> $past(modeBitLoad));

  // R7
  invalid_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    invalidWidth |-> (result == '0));
endmodule

// File: tb/bitfield_extract_bench.sv
module bitfield_extract_bench;
  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              modeBitLoad = 1'b0;
  logic [63:0]       operand = '0;
  logic [15:0]       ctrlWord = '0;
  logic [7:0]        widthField = '0;
  logic [ADDR_W-1:0] bitPos = '0;
  logic [ADDR_W-1:0] baseAddr = '0;
  logic [63:0]       result;
  logic              invalidWidth;
  logic [ADDR_W-1:0] byteAddr;

  int checks = 0;
  int failures = 0;

  bitfield_extract #(.ADDR_W(ADDR_W)) u_bitfield_extract (
    .clk(clk), .rstN(rstN), .modeBitLoad(modeBitLoad), .operand(operand),
    .ctrlWord(ctrlWord), .widthField(widthField), .bitPos(bitPos),
    .baseAddr(baseAddr), .result(result), .invalidWidth(invalidWidth),
    .byteAddr(byteAddr)
  );

  always #10 clk = ~clk;

  function automatic logic [63:0] lowBits(input int n);
    logic [63:0] m = '0;
    for (int i = 0; i < n; i++) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [63:0] refPacked(input logic [63:0] op, input logic [15:0] cw);
    int s = int'($signed(cw[7:0]));
    int m = int'(cw[15:8]);
    logic [63:0] v;
    if (s >= 0) v = op << (s % 64);
    else        v = op >> ((-s) % 64);
    if (m >= 1 && m <= 63) v = v & lowBits(m);
    return v;
  endfunction

  function automatic logic [63:0] refLoad(input logic [63:0] op, input logic [ADDR_W-1:0] pos,
                                          input logic [7:0] w);
    logic [63:0] v = op >> (pos % 8);
    if (w > 8'd56) return '0;
    if (w != 8'd0) v = v & lowBits(int'(w));
    return v;
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic cmp(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic applyPacked(input logic [63:0] op, input logic [15:0] cw, input string req);
    @(negedge clk);
    modeBitLoad = 1'b0; operand = op; ctrlWord = cw;
    widthField = 8'($urandom()); bitPos = $urandom(); baseAddr = $urandom();
    @(posedge clk); #1;
    cmp(req, "packed result", result, refPacked(op, cw));
    cmp("R7", "packed invalid", {63'd0, invalidWidth}, 64'd0);
  endtask

  task automatic applyLoad(input logic [63:0] op, input logic [ADDR_W-1:0] pos,
                           input logic [7:0] w, input string req);
    @(negedge clk);
    modeBitLoad = 1'b1; operand = op; bitPos = pos; widthField = w;
    ctrlWord = 16'($urandom()); baseAddr = $urandom();
    @(posedge clk); #1;
    cmp(req, "load result", result, refLoad(op, pos, w));
    cmp("R7", "load invalid", {63'd0, invalidWidth}, {63'd0, (w > 8'd56)});
  endtask

  task automatic testReset();
    @(negedge clk);
    modeBitLoad = 1'b1; operand = '1; widthField = 8'd200; baseAddr = 32'h1234;
    @(posedge clk); #1;
    cmp("R9", "reset result", result, 64'd0);
    cmp("R9", "reset invalid", {63'd0, invalidWidth}, 64'd0);
    cmp("R9", "reset addr", 64'(byteAddr), 64'd0);
  endtask

  task automatic testLeftShifts();
    for (int s = 0; s < 128; s++) applyPacked(rnd64(), {8'd0, 8'(s)}, "R1");
    applyPacked(64'h8000_0000_0000_0001, 16'h0001, "R1");
  endtask

  task automatic testRightShifts();
    for (int s = 1; s <= 128; s++) applyPacked(rnd64(), {8'd0, 8'(-s)}, "R2");
    applyPacked(64'hFFFF_FFFF_FFFF_FFFF, 16'h00C1, "R2");
    applyPacked(64'hDEAD_BEEF_0000_0001, 16'h0080, "R2");
  endtask

  task automatic testMaskCodes();
    for (int m = 1; m < 64; m++) applyPacked(rnd64(), {8'(m), 8'($urandom())}, "R3");
    applyPacked('1, 16'h3F00, "R3");
    applyPacked('1, 16'h0100, "R3");
    for (int m = 64; m < 256; m++) applyPacked(rnd64(), {8'(m), 8'($urandom())}, "R4");
    applyPacked('1, 16'h0000, "R4");
    applyPacked('1, 16'hFF00, "R4");
    applyPacked('1, 16'hFFFC, "R4");
  endtask

  task automatic testCrossCodes();
    for (int i = 0; i < 600; i++) applyPacked(rnd64(), 16'($urandom()), "R3");
  endtask

  task automatic testLoadShift();
    for (int p = 0; p < 16; p++) applyLoad(rnd64(), ADDR_W'(p), 8'd0, "R5");
    applyLoad(64'hFFFF_FFFF_FFFF_FFFF, 32'd7, 8'd0, "R5");
  endtask

  task automatic testLoadWidths();
    for (int w = 0; w <= 56; w++) applyLoad(rnd64(), $urandom(), 8'(w), "R6");
    applyLoad('1, 32'd0, 8'd56, "R6");
    for (int w = 57; w < 256; w++) applyLoad('1, $urandom(), 8'(w), "R7");
  endtask

  task automatic testAddr();
    logic [ADDR_W-1:0] b;
    logic [ADDR_W-1:0] p;
    for (int i = 0; i < 40; i++) begin
      b = $urandom(); p = $urandom();
      if (i == 0) begin b = 32'hFFFF_FFFF; p = 32'h0000_0010; end
      @(negedge clk);
      modeBitLoad = 1'b1; baseAddr = b; bitPos = p; widthField = 8'd8; operand = rnd64();
      @(posedge clk); #1;
      cmp("R8", "byte address", 64'(byteAddr), 64'(ADDR_W'(b + (p >> 3))));
    end
  endtask

  task automatic testLatency();
    logic [63:0] op = 64'h0123_4567_89AB_CDEF;
    @(negedge clk);
    modeBitLoad = 1'b0; operand = op; ctrlWord = 16'h0004;
    @(posedge clk); #1;
    cmp("R9", "first result", result, op << 4);
    @(negedge clk);
    ctrlWord = 16'h08FC;
    #2;
    cmp("R9", "held before edge", result, op << 4);
    @(posedge clk); #1;
    cmp("R9", "next result", result, 64'h0000_0000_0000_00DE);
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    testLeftShifts();
    testRightShifts();
    testMaskCodes();
    testCrossCodes();
    testLoadShift();
    testLoadWidths();
    testAddr();
    testLatency();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule